// File: doc/BRIEF.md
# I2C Message Transaction Sequencer

This block walks a list of I2C messages on its own, sitting above a byte-level I2C controller that executes one command at a time and reports each completion. The caller supplies a message count and starts the run; the sequencer then reads each message's settings (7-bit target address, direction, byte count, and a flag that suppresses the repeated start) through a small indexed lookup. Write bytes are taken from a valid/ready input stream, and received bytes leave on a valid/ready output stream.

On every controller completion the sequencer looks at the completion status and decides the next command. It handles the address phase, the data bytes, repeated starts between messages, the closing stop, and error stops after a NACK or lost arbitration. The stop completion is answered with an interrupt acknowledge, and a one-cycle done or error pulse marks the end. A programmable cycle-count watchdog ends a run that stalls, issuing a stop and a timeout pulse.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `cmd_valid`, `wready`, `rvalid`, `done`, `error` and `timeout` are all low.
- R2: Every message's address phase is a start command (op 0) whose byte is the address in bits 7:1 with bit 0 = 1 for a read and 0 for a write. The first message always gets a start.
- R3: Each write byte is issued as op 1 with the byte taken from the write stream at the `wvalid`/`wready` handshake. Bytes go out in stream order, and no byte is consumed before the previous write has completed.
- R4: Read bytes are requested with op 2 (ACK), except the last byte of a message, which uses op 3 (NACK). Each received byte appears on `rdata`/`rvalid`. No new read is requested while an unaccepted byte is held, and a held byte stays stable until it is taken.
- R5: Between messages a new start with a fresh address byte is issued, unless the next message has its no-start flag set. In that case its data bytes follow directly.
- R6: After the last byte of the last message completes, a stop (op 4) is issued. The stop's completion is answered with an interrupt acknowledge (op 5) in the same cycle as a one-cycle `done` pulse, and the block goes idle.
- R7: A NACK on the completion of an address or write byte causes a stop, then acknowledge plus `error`. No further write bytes are taken from the stream.
- R8: Arbitration loss on any completion causes a stop, then acknowledge plus `error`. The byte of that completion is not delivered.
- R9: If a run has not ended `timeout_cycles` cycles after start (0 disables), a stop is issued with a one-cycle `timeout` pulse, and the block returns idle.
- R10: A start with a message count of 0 gives a `done` pulse and issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a run (sampled while idle) |
| msg_count | input | IDX_W+1 | Number of messages in the run |
| timeout_cycles | input | TMO_W | Watchdog limit in cycles, 0 = off |
| desc_idx | output | IDX_W | Index of the current message |
| desc_addr | input | 7 | 7-bit target address of message `desc_idx` |
| desc_rd | input | 1 | 1 = read message |
| desc_len | input | LEN_W | Byte count of the message |
| desc_nostart | input | 1 | Skip the repeated start before this message |
| wdata | input | 8 | Write stream byte |
| wvalid | input | 1 | Write stream valid |
| wready | output | 1 | Write stream ready |
| rdata | output | 8 | Read stream byte |
| rvalid | output | 1 | Read stream valid |
| rready | input | 1 | Read stream ready |
| cmd_valid | output | 1 | One-cycle command strobe to the controller |
| cmd_op | output | 3 | 0 start, 1 write, 2 read+ACK, 3 read+NACK, 4 stop, 5 irq ack |
| cmd_byte | output | 8 | Byte sent with start/write |
| cpl_valid | input | 1 | Controller completion strobe |
| cpl_nack | input | 1 | Target did not acknowledge |
| cpl_arblost | input | 1 | Arbitration was lost |
| cpl_rdata | input | 8 | Byte received by a read |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished cleanly (pulse) |
| error | output | 1 | Run ended after NACK or arbitration loss (pulse) |
| timeout | output | 1 | Run ended by the watchdog (pulse) |

## Verification
A wrong phase shows up on the command port at the very next completion. After an address phase the block would send a write where a read was due, or a start where data should follow. A wrong byte position moves the ACK-to-NACK switch, or the point where the stop appears, by one command. A wrong message index shows as a wrong address byte at the next repeated start. Errors handled as success show up when a NACK or arbitration loss is not followed within one cycle by a stop, and the run then ends in `done` rather than `error`.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    OP_START_WR  = 3'd0,
    OP_WRITE     = 3'd1,
    OP_READ_ACK  = 3'd2,
    OP_READ_NACK = 3'd3,
    OP_STOP      = 3'd4,
    OP_IACK      = 3'd5
  } cmd_op_e;

  typedef enum logic [2:0] {
    PH_DONE, PH_START, PH_WRITE, PH_READ, PH_ERROR
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_NEXT, S_WAIT, S_WDATA, S_RSLOT, S_ADV
  } fsm_e;
endpackage

// File: rtl/sq_watchdog.sv
module sq_watchdog #(
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             fire
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (run) begin
        cnt  <= cnt + 1'b1;
        fire <= (limit != '0) && (cnt == limit - 1'b1);
      end
    end
  end

  // R9: expiry only follows a cycle in which a run was active
  assert_fire_needs_run_R9: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(run));
endmodule

// File: rtl/sq_rd_slot.sv
module sq_rd_slot (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] din,
  output logic [7:0] rdata,
  output logic       rvalid,
  input  logic       rready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (load) begin
      rvalid <= 1'b1;
      rdata  <= din;
    end else if (rready) begin
      rvalid <= 1'b0;
    end
  end

  // R4: a held byte is never overwritten and stays put under backpressure
  assert_no_overrun_R4: assert property (@(posedge clk) disable iff (rst)
    load |-> !rvalid);
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready && !load) |=> (rvalid && $stable(rdata)));
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2c_seq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LEN_W = 8,
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [IDX_W:0]   msg_count,
  input  logic [TMO_W-1:0] timeout_cycles,
  output logic [IDX_W-1:0] desc_idx,
  input  logic [6:0]       desc_addr,
  input  logic             desc_rd,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             desc_nostart,
  input  logic [7:0]       wdata,
  input  logic             wvalid,
  output logic             wready,
  output logic [7:0]       rdata,
  output logic             rvalid,
  input  logic             rready,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  input  logic             cpl_valid,
  input  logic             cpl_nack,
  input  logic             cpl_arblost,
  input  logic [7:0]       cpl_rdata,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             timeout
);
  localparam logic [IDX_W:0] ONE_IDX = {{IDX_W{1'b0}}, 1'b1};

  fsm_e             st;
  phase_e           ph;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] pos;
  logic             first;
  cmd_op_e          op_q;
  logic             wd_fire;
  logic             rd_load;
  logic [LEN_W-1:0] pos_after;
  logic             last_msg;
  phase_e           data_ph;

  assign desc_idx  = idx;
  assign cmd_op    = op_q;
  assign busy      = (st != S_IDLE);
  assign wready    = (st == S_WDATA);
  assign pos_after = (ph == PH_READ) ? pos + 1'b1 : pos;
  assign last_msg  = (({1'b0, idx} + ONE_IDX) == msg_count);
  assign data_ph   = desc_rd ? PH_READ : PH_WRITE;
  assign rd_load   = (st == S_WAIT) && cpl_valid && (ph == PH_READ) && !cpl_arblost;

  sq_watchdog #(.TMO_W(TMO_W)) u_wd (
    .clk   (clk),
    .rst   (rst),
    .arm   (st == S_IDLE && go),
    .run   (busy),
    .limit (timeout_cycles),
    .fire  (wd_fire)
  );

  sq_rd_slot u_slot (
    .clk    (clk),
    .rst    (rst),
    .load   (rd_load),
    .din    (cpl_rdata),
    .rdata  (rdata),
    .rvalid (rvalid),
    .rready (rready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ph        <= PH_DONE;
      idx       <= '0;
      pos       <= '0;
      first     <= 1'b0;
      op_q      <= OP_IACK;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      timeout   <= 1'b0;
      if (wd_fire && st != S_IDLE) begin
        cmd_valid <= 1'b1;
        op_q      <= OP_STOP;
        timeout   <= 1'b1;
        st        <= S_IDLE;
      end else begin
        unique case (st)
          S_IDLE: if (go) begin
            idx   <= '0;
            pos   <= '0;
            first <= 1'b1;
            if (msg_count == '0) done <= 1'b1;
            else                 st   <= S_NEXT;
          end
          S_NEXT: begin
            pos <= '0;
            if (first || !desc_nostart) begin
              cmd_valid <= 1'b1;
              op_q      <= OP_START_WR;
              cmd_byte  <= {desc_addr, desc_rd};
              ph        <= PH_START;
              first     <= 1'b0;
              st        <= S_WAIT;
            end else if (desc_len == '0) begin
              st <= S_ADV;
            end else begin
              ph <= data_ph;
              st <= desc_rd ? S_RSLOT : S_WDATA;
            end
          end
          S_WAIT: if (cpl_valid) begin
            if (ph == PH_DONE || ph == PH_ERROR) begin
              cmd_valid <= 1'b1;
              op_q      <= OP_IACK;
              done      <= (ph == PH_DONE);
              error     <= (ph == PH_ERROR);
              st        <= S_IDLE;
            end else if (cpl_arblost || (ph != PH_READ && cpl_nack)) begin
              cmd_valid <= 1'b1;
              op_q      <= OP_STOP;
              ph        <= PH_ERROR;
            end else begin
              pos <= pos_after;
              ph  <= data_ph;
              if (pos_after == desc_len) st <= S_ADV;
              else                       st <= desc_rd ? S_RSLOT : S_WDATA;
            end
          end
          S_ADV: begin
            if (last_msg) begin
              cmd_valid <= 1'b1;
              op_q      <= OP_STOP;
              ph        <= PH_DONE;
              st        <= S_WAIT;
            end else begin
              idx <= idx + 1'b1;
              st  <= S_NEXT;
            end
          end
          S_WDATA: if (wvalid) begin
            cmd_valid <= 1'b1;
            op_q      <= OP_WRITE;
            cmd_byte  <= wdata;
            pos       <= pos + 1'b1;
            st        <= S_WAIT;
          end
          S_RSLOT: if (!rvalid) begin
            cmd_valid <= 1'b1;
            op_q      <= (pos == desc_len - 1'b1) ? OP_READ_NACK : OP_READ_ACK;
            st        <= S_WAIT;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3: an accepted write beat becomes a write command carrying that byte
  assert_wr_from_beat_R3: assert property (@(posedge clk) disable iff (rst)
    (wvalid && wready) |=> (cmd_valid && cmd_op == OP_WRITE && cmd_byte == $past(wdata)));
  // R4: no read request while the output slot holds a byte
  assert_rd_needs_room_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op == OP_READ_ACK || cmd_op == OP_READ_NACK)) |-> !rvalid);
  // R6, R7, R8: a clean or failed end coincides with the interrupt acknowledge
  assert_end_with_iack_R6: assert property (@(posedge clk) disable iff (rst)
    (done && busy == 1'b0 && $past(busy)) |-> (cmd_valid && cmd_op == OP_IACK));
  assert_err_with_iack_R7: assert property (@(posedge clk) disable iff (rst)
    error |-> (cmd_valid && cmd_op == OP_IACK && !done));
  // R8: arbitration loss is answered by a stop in the next cycle
  assert_arb_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && cpl_arblost && st == S_WAIT && ph != PH_DONE && ph != PH_ERROR && !wd_fire)
      |=> (cmd_valid && cmd_op == OP_STOP));
  // R9: a timeout pulse always carries a stop and leaves the block idle
  assert_tmo_stop_R9: assert property (@(posedge clk) disable iff (rst)
    timeout |-> (cmd_valid && cmd_op == OP_STOP && !busy));
endmodule

// File: tb/sim_i2c_msg_seq.sv
module sim_i2c_msg_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go = 1'b0;
  logic [4:0]  msg_count = '0;
  logic [19:0] timeout_cycles = 20'd2000;
  logic [3:0]  desc_idx;
  logic [6:0]  desc_addr;
  logic        desc_rd, desc_nostart;
  logic [7:0]  desc_len;
  logic [7:0]  wdata = 8'h50;
  logic        wvalid = 1'b1, wready;
  logic [7:0]  rdata;
  logic        rvalid, rready = 1'b1;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_byte;
  logic        cpl_valid = 1'b0, cpl_nack = 1'b0, cpl_arblost = 1'b0;
  logic [7:0]  cpl_rdata = '0;
  logic        busy, done, error, timeout;

  logic [6:0] d_addr [4];
  logic       d_rd [4];
  logic [7:0] d_len [4];
  logic       d_ns [4];
  assign desc_addr    = d_addr[desc_idx[1:0]];
  assign desc_rd      = d_rd[desc_idx[1:0]];
  assign desc_len     = d_len[desc_idx[1:0]];
  assign desc_nostart = d_ns[desc_idx[1:0]];

  always #5 clk = ~clk;

  i2c_msg_seq u0 (.*);

  // op codes as stated in R2..R6
  localparam logic [2:0] C_START = 3'd0, C_WR = 3'd1, C_RDA = 3'd2,
                         C_RDN = 3'd3, C_STOP = 3'd4, C_IACK = 3'd5;

  // {set, nmsg, nack_at, arb_at, expected commands, expected error}
  localparam logic [31:0] VEC [8] = '{
    32'h01FFFF50, 32'h11FFFF60, 32'h22FFFF70, 32'h32FFFF60,
    32'h0100FF31, 32'h0101FF41, 32'h11FF0251, 32'h00FFFF00
  };

  int nchk = 0, nfail = 0;
  logic [2:0] op_log [32];
  logic [7:0] byte_log [32];
  logic [7:0] rd_log [16];
  int ncmd = 0, nrd = 0, wcnt = 0, dly = 0, cyc = 0;
  int nack_at = 255, arb_at = 255;
  logic mute = 1'b0;
  logic p_nack, p_arb;
  logic [7:0] p_rd;
  logic saw_done = 0, saw_err = 0, saw_tmo = 0;

  // controller model and stream sink/source, all on the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cpl_valid) begin cpl_valid = 1'b0; cpl_nack = 1'b0; cpl_arblost = 1'b0; end
    if (dly > 0) begin
      dly = dly - 1;
      if (dly == 0) begin
        cpl_valid = 1'b1; cpl_nack = p_nack; cpl_arblost = p_arb; cpl_rdata = p_rd;
      end
    end
    if (cmd_valid) begin
      if (ncmd < 32) begin op_log[ncmd] = cmd_op; byte_log[ncmd] = cmd_byte; end
      if (cmd_op == C_WR) begin wcnt = wcnt + 1; wdata = 8'h50 + 8'(wcnt); end
      if (cmd_op != C_IACK && !mute) begin
        dly    = 2;
        p_nack = (ncmd == nack_at) && (cmd_op == C_START || cmd_op == C_WR);
        p_arb  = (ncmd == arb_at);
        p_rd   = 8'hA0 + 8'(ncmd);
      end
      ncmd = ncmd + 1;
    end
    if (rvalid && rready) begin
      if (nrd < 16) rd_log[nrd] = rdata;
      nrd = nrd + 1;
    end
    if (done) saw_done = 1;
    if (error) saw_err = 1;
    if (timeout) saw_tmo = 1;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load_set(input int s);
    for (int i = 0; i < 4; i++) begin d_addr[i] = '0; d_rd[i] = 0; d_len[i] = 0; d_ns[i] = 0; end
    case (s)
      0: begin d_addr[0] = 7'h2A; d_len[0] = 2; end
      1: begin d_addr[0] = 7'h11; d_rd[0] = 1; d_len[0] = 3; end
      2: begin d_addr[0] = 7'h30; d_len[0] = 1; d_addr[1] = 7'h30; d_rd[1] = 1; d_len[1] = 2; end
      default: begin d_addr[0] = 7'h45; d_len[0] = 1; d_addr[1] = 7'h45; d_len[1] = 2; d_ns[1] = 1; end
    endcase
  endtask

  task automatic launch(input int s, input int n, input int nk, input int ab);
    @(negedge clk);
    load_set(s);
    msg_count = 5'(n); nack_at = nk; arb_at = ab;
    ncmd = 0; nrd = 0; wcnt = 0; wdata = 8'h50;
    saw_done = 0; saw_err = 0; saw_tmo = 0;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic finish_wait(input string tag);
    int k = 0;
    while (!(saw_done || saw_err || saw_tmo) && k < 3000) begin @(negedge clk); k++; end
    chk(k < 3000, {tag, " watchdog"}, k, 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL global watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    load_set(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !cmd_valid && !wready && !rvalid && !done && !error && !timeout,
        "R1 idle after reset", {busy, cmd_valid, wready, rvalid}, 0);

    // table walk: R6 R7 R8 R10 outcomes and command counts
    foreach (VEC[v]) begin
      int s, n, nk, ab, ec, ee;
      s = int'(VEC[v][31:28]); n = int'(VEC[v][27:24]); nk = int'(VEC[v][23:16]);
      ab = int'(VEC[v][15:8]); ec = int'(VEC[v][7:4]); ee = int'(VEC[v][3:0]);
      launch(s, n, nk, ab);
      finish_wait("table");
      chk(ncmd == ec, "R6/R7/R8/R10 command count", ncmd, ec);
      chk(saw_err == (ee != 0) && saw_done == (ee == 0), "R6/R7/R8 outcome", {saw_done, saw_err}, ee);
      if (ec >= 2) begin
        chk(op_log[ec-1] == C_IACK, "R6 final acknowledge", op_log[ec-1], C_IACK);
        chk(op_log[ec-2] == C_STOP, "R6 stop before acknowledge", op_log[ec-2], C_STOP);
      end
      chk(!busy, "R6 idle at end", busy, 0);
      if (v == 0) begin
        chk(op_log[0] == C_START && byte_log[0] == 8'h54, "R2 write address byte", byte_log[0], 8'h54);
        chk(op_log[1] == C_WR && byte_log[1] == 8'h50, "R3 first write byte", byte_log[1], 8'h50);
        chk(op_log[2] == C_WR && byte_log[2] == 8'h51, "R3 second write byte", byte_log[2], 8'h51);
      end
      if (v == 1) begin
        chk(byte_log[0] == 8'h23, "R2 read address byte", byte_log[0], 8'h23);
        chk(op_log[1] == C_RDA && op_log[2] == C_RDA, "R4 ACK reads", {op_log[1], op_log[2]}, 8'h22);
        chk(op_log[3] == C_RDN, "R4 NACK on last read", op_log[3], C_RDN);
        chk(nrd == 3 && rd_log[0] == 8'hA1 && rd_log[2] == 8'hA3, "R4 read stream", rd_log[2], 8'hA3);
      end
      if (v == 2) begin
        chk(op_log[2] == C_START && byte_log[2] == 8'h61, "R5 repeated start", byte_log[2], 8'h61);
        chk(op_log[3] == C_RDA && op_log[4] == C_RDN, "R4 two-byte read", op_log[4], C_RDN);
      end
      if (v == 3) begin
        chk(op_log[2] == C_WR && op_log[3] == C_WR && byte_log[3] == 8'h52,
            "R5 no-start continuation", op_log[2], C_WR);
      end
      if (v == 4) chk(op_log[1] == C_STOP && wcnt == 0, "R7 address NACK", wcnt, 0);
      if (v == 5) chk(op_log[2] == C_STOP && wcnt == 1, "R7 write NACK stops stream", wcnt, 1);
      if (v == 6) chk(nrd == 1 && op_log[3] == C_STOP, "R8 lost byte not delivered", nrd, 1);
    end

    // R4 backpressure: no second read while a byte is held
    rready = 1'b0;
    launch(1, 1, 255, 255);
    repeat (60) @(negedge clk);
    chk(ncmd == 2, "R4 stall on backpressure", ncmd, 2);
    chk(rvalid && rdata == 8'hA1, "R4 held byte", rdata, 8'hA1);
    rready = 1'b1;
    finish_wait("backpressure");
    chk(ncmd == 6 && saw_done && nrd == 3, "R4 resumes after release", ncmd, 6);

    // R9 timeout: controller never answers
    mute = 1'b1;
    timeout_cycles = 20'd30;
    begin
      int t0;
      launch(0, 1, 255, 255);
      t0 = cyc;
      finish_wait("timeout");
      chk(saw_tmo && !saw_done && !saw_err, "R9 timeout pulse", saw_tmo, 1);
      chk(ncmd == 2 && op_log[1] == C_STOP, "R9 stop on timeout", op_log[1], C_STOP);
      chk(!busy, "R9 idle after timeout", busy, 0);
      t0 = cyc - t0 - 6;
      chk(t0 >= 29 && t0 <= 33, "R9 timeout latency", t0, 30);
    end
    mute = 1'b0;
    timeout_cycles = 20'd2000;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule